// File: doc/BRIEF.md
# Signed-Count Dual-Output PWM Timer

This block is one PWM timer with two outputs. A signed counter starts at a programmable start value and steps up by one on each prescaled tick. When the counter equals the period compare value, it returns to the start value. Six compare values drive the timer. One sets the period end. One marks the mid-period point. The other four set when output A and output B rise and fall. Because each output has its own rise and fall values, output B can trail output A by any count offset.

A three-bit divider code slows the count rate by a power of two. A run input freezes or releases the timer. A pair-mode input makes output B either independent or the inverse of output A. A per-output enable forces that pin low. Each compare match sets a sticky flag, and the period end also sets a reload flag. Software clears flags by writing ones. A masked OR of the flags drives an interrupt line. The start and compare values come from a buffer stage outside this block. One-cycle period-end and mid-period pulses tell that buffer stage when it may swap in new values.

Top module: `sdpwm_gen`

## Requirements
- R1: While `rst` is high, the next clock edge loads `count` with `init_val` and clears `pwm_a`, `pwm_b`, `flags`, `irq`, `full_evt` and `half_evt` to 0.
- R2: Each prescaled tick with no period match steps `count` up by one, using 16-bit two's complement, so 32767 is followed by -32768.
- R3: A tick taken while `count` equals compare slot 1 (bits 31:16 of `cmp_vals`) reloads `count` with `init_val`. At that same edge it sets `flags[1]` and `flags[6]` and raises `full_evt` for one cycle.
- R4: A tick taken while `count` equals compare slot 0 (bits 15:0) sets `flags[0]` and raises `half_evt` for one cycle. It does not change how the count proceeds.
- R5: `prsc` value n gives one tick every 2^n cycles in which `run` is high, for n from 0 to 7. The first tick after reset comes on the 2^n-th such cycle.
- R6: A tick matching slot 2 sets output A's level to 1. A tick matching slot 3 sets it to 0. If both match on the same tick, the level becomes 0.
- R7: With `pair_sel` = 0, slot 4 sets output B's level to 1 and slot 5 sets it to 0, again with fall taking priority. Slots 4 and 5 do not affect output A.
- R8: With `pair_sel` = 1, output B is the inverse of output A's level, and slots 4 and 5 have no effect on `pwm_b`.
- R9: When an enable input is low, its pin drives 0 from the next edge on. The hidden level keeps tracking compare matches, and it appears at the pin as soon as the enable returns.
- R10: While `run` is low, `count`, the prescaler phase and both output levels hold their values.
- R11: A compare match on slot k sets `flags[k]`, and that flag stays set until `flag_clr[k]` is high for a cycle. If a set and a clear arrive on the same edge, the set wins.
- R12: `irq` is registered. After each edge it equals the OR of the new `flags` ANDed bit by bit with the `irq_en` value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Lets the prescaler and counter advance |
| prsc | input | 3 | Divider code; the tick rate is clk / 2^prsc |
| pair_sel | input | 1 | 0 = independent outputs, 1 = B is the inverse of A |
| en_a | input | 1 | Output A pin enable |
| en_b | input | 1 | Output B pin enable |
| init_val | input | 16 | Signed start value loaded at reset and at each period end |
| cmp_vals | input | 96 | Six signed compare slots; slot k is at bits 16k+15:16k |
| flag_clr | input | 7 | Write-one-to-clear strobes for the flags |
| irq_en | input | 7 | Interrupt mask, one bit per flag position |
| count | output | 16 | Current signed count |
| pwm_a | output | 1 | Output A pin |
| pwm_b | output | 1 | Output B pin |
| flags | output | 7 | Bits 5:0 are compare matches; bit 6 is the reload flag |
| irq | output | 1 | Masked interrupt request |
| full_evt | output | 1 | One-cycle pulse at each period end |
| half_evt | output | 1 | One-cycle pulse at each mid-period match |

## Verification
The bench uses the default parameters: a 16-bit count and a 3-bit divider code. With these values the test can reach the real two's complement wrap from 32767 to -32768, and the slowest divider setting (one tick per 128 cycles) still fits in a short run. Short periods are used, with start values such as -3 and -2. This lets many period ends, mid-period matches, outputs shifted in phase and same-count rise/fall collisions happen within a few hundred cycles. The bench also switches the divider setting, the run input, the enables and the pair mode, and checks each change against a cycle model written from the requirements.

// File: rtl/sdpwm_pkg.sv
package sdpwm_pkg;
  localparam int NCMP       = 6;
  localparam int NFLAG      = NCMP + 1;
  localparam int IDX_HALF   = 0;
  localparam int IDX_FULL   = 1;
  localparam int IDX_A_ON   = 2;
  localparam int IDX_A_OFF  = 3;
  localparam int IDX_B_ON   = 4;
  localparam int IDX_B_OFF  = 5;
  localparam int IDX_RELOAD = 6;

  typedef enum logic {
    PAIR_INDEP = 1'b0,
    PAIR_COMP  = 1'b1
  } pair_mode_e;

  // fall has priority over rise on a shared count
  function automatic logic next_level(input logic cur, input logic rise, input logic fall);
    if (fall)      return 1'b0;
    else if (rise) return 1'b1;
    else           return cur;
  endfunction
endpackage

// File: rtl/sdpwm_prescale.sv
module sdpwm_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << sel);
    tick = run && ((phase & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (run) phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/sdpwm_compare.sv
module sdpwm_compare #(
  parameter int W = 16,
  parameter int N = 6
) (
  input  logic [W-1:0]   count,
  input  logic           tick,
  input  logic [N*W-1:0] vals,
  output logic [N-1:0]   hit
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign hit[g] = tick && (count == vals[g*W +: W]);
  end
endmodule

// File: rtl/sdpwm_counter.sv
module sdpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] start,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= start;
    else if (tick) count <= wrap ? start : count + W'(1);
  end
endmodule

// File: rtl/sdpwm_outstage.sv
module sdpwm_outstage
  import sdpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_a,
  input  logic       fall_a,
  input  logic       rise_b,
  input  logic       fall_b,
  input  logic       en_a,
  input  logic       en_b,
  input  pair_mode_e mode,
  output logic       pin_a,
  output logic       pin_b
);
  logic lvl_a, lvl_b;
  logic nxt_a, nxt_b;

  always_comb begin
    nxt_a = next_level(lvl_a, rise_a, fall_a);
    nxt_b = next_level(lvl_b, rise_b, fall_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_a <= 1'b0;
      lvl_b <= 1'b0;
      pin_a <= 1'b0;
      pin_b <= 1'b0;
    end else begin
      lvl_a <= nxt_a;
      lvl_b <= nxt_b;
      pin_a <= en_a & nxt_a;
      pin_b <= en_b & ((mode == PAIR_COMP) ? ~nxt_a : nxt_b);
    end
  end
endmodule

// File: rtl/sdpwm_status.sv
module sdpwm_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] nxt;

  always_comb nxt = (sts & ~clr) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= nxt;
      irq <= |(nxt & mask);
    end
  end
endmodule

// File: rtl/sdpwm_gen.sv
module sdpwm_gen
  import sdpwm_pkg::*;
#(
  parameter int W      = 16,
  parameter int PRSC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRSC_W-1:0] prsc,
  input  logic              pair_sel,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [W-1:0]      init_val,
  input  logic [NCMP*W-1:0] cmp_vals,
  input  logic [NFLAG-1:0]  flag_clr,
  input  logic [NFLAG-1:0]  irq_en,
  output logic [W-1:0]      count,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [NFLAG-1:0]  flags,
  output logic              irq,
  output logic              full_evt,
  output logic              half_evt
);
  logic            tick;
  logic [NCMP-1:0] hit;
  pair_mode_e      mode;

  assign mode = pair_mode_e'(pair_sel);

  sdpwm_prescale #(.SEL_W(PRSC_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .sel(prsc), .tick(tick)
  );

  sdpwm_compare #(.W(W), .N(NCMP)) u_cmp (
    .count(count), .tick(tick), .vals(cmp_vals), .hit(hit)
  );

  sdpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wrap(hit[IDX_FULL]),
    .start(init_val), .count(count)
  );

  sdpwm_outstage u_out (
    .clk(clk), .rst(rst),
    .rise_a(hit[IDX_A_ON]), .fall_a(hit[IDX_A_OFF]),
    .rise_b(hit[IDX_B_ON]), .fall_b(hit[IDX_B_OFF]),
    .en_a(en_a), .en_b(en_b), .mode(mode),
    .pin_a(pwm_a), .pin_b(pwm_b)
  );

  sdpwm_status #(.N(NFLAG)) u_sts (
    .clk(clk), .rst(rst), .set_v({hit[IDX_FULL], hit}),
    .clr(flag_clr), .mask(irq_en), .sts(flags), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full_evt <= 1'b0;
      half_evt <= 1'b0;
    end else begin
      full_evt <= hit[IDX_FULL];
      half_evt <= hit[IDX_HALF];
    end
  end
endmodule

// File: rtl/sdpwm_chk.sv
module sdpwm_chk #(
  parameter int W      = 16,
  parameter int PRSC_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              tick,
  input logic [PRSC_W-1:0] prsc,
  input logic              pair_sel,
  input logic              en_a,
  input logic              en_b,
  input logic [W-1:0]      init_val,
  input logic [5:0]        hit,
  input logic [W-1:0]      count,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic [6:0]        flags,
  input logic [6:0]        flag_clr,
  input logic [6:0]        irq_en,
  input logic              irq
);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick && !hit[1] |=> count == W'($past(count) + W'(1)));
  p_full_reload_r3: assert property (@(posedge clk) disable iff (rst)
    hit[1] |=> count == $past(init_val));
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick && prsc != '0 |=> !tick || prsc != $past(prsc));
  p_fall_a_r6: assert property (@(posedge clk) disable iff (rst)
    hit[3] |=> !pwm_a);
  p_rise_a_r6: assert property (@(posedge clk) disable iff (rst)
    hit[2] && !hit[3] && en_a |=> pwm_a);
  p_comp_r8: assert property (@(posedge clk) disable iff (rst)
    pair_sel && en_a && en_b |=> pwm_b != pwm_a);
  p_dis_a_r9: assert property (@(posedge clk) disable iff (rst)
    !en_a |=> !pwm_a);
  p_dis_b_r9: assert property (@(posedge clk) disable iff (rst)
    !en_b |=> !pwm_b);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count));
  p_set_r11: assert property (@(posedge clk) disable iff (rst)
    |hit |=> (flags[5:0] & $past(hit)) == $past(hit));
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr));
  p_irq_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == |(flags & $past(irq_en)));
endmodule

bind sdpwm_gen sdpwm_chk #(.W(W), .PRSC_W(PRSC_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .tick(tick), .prsc(prsc),
  .pair_sel(pair_sel), .en_a(en_a), .en_b(en_b), .init_val(init_val),
  .hit(hit), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .flags(flags), .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq)
);

// File: tb/sdpwm_gen_tb.sv
module sdpwm_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [2:0] prsc = '0;
  logic pair_sel = 1'b0;
  logic en_a = 1'b0, en_b = 1'b0;
  logic signed [15:0] init_v = '0;
  logic signed [15:0] v [6];
  logic [6:0] clr = '0, ien = '0;
  logic [15:0] count;
  logic pwm_a, pwm_b, irq, full_evt, half_evt;
  logic [6:0] flags;

  int checks = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdpwm_gen u_dut (
    .clk(clk), .rst(rst), .run(run), .prsc(prsc), .pair_sel(pair_sel),
    .en_a(en_a), .en_b(en_b), .init_val(init_v),
    .cmp_vals({v[5], v[4], v[3], v[2], v[1], v[0]}),
    .flag_clr(clr), .irq_en(ien), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flags(flags), .irq(irq), .full_evt(full_evt), .half_evt(half_evt)
  );

  // cycle model built from the requirements
  logic signed [15:0] m_cnt;
  logic [7:0] m_div;
  logic m_a, m_b, m_pa, m_pb, m_irq, m_full, m_half;
  logic [6:0] m_sts;

  always @(posedge clk) begin : model
    logic mt, an, bn;
    logic [5:0] mh;
    logic [6:0] sn;
    if (rst) begin
      m_cnt <= init_v; m_div <= '0; m_a <= 0; m_b <= 0; m_pa <= 0; m_pb <= 0;
      m_sts <= '0; m_irq <= 0; m_full <= 0; m_half <= 0;
    end else begin
      mt = run && (m_div == ((8'd1 << prsc) - 8'd1));
      if (run) m_div <= mt ? 8'd0 : m_div + 8'd1;
      for (int k = 0; k < 6; k++) mh[k] = mt && (m_cnt == v[k]);
      if (mt) m_cnt <= mh[1] ? init_v : m_cnt + 16'sd1;
      an = mh[3] ? 1'b0 : (mh[2] ? 1'b1 : m_a);
      bn = mh[5] ? 1'b0 : (mh[4] ? 1'b1 : m_b);
      m_a <= an; m_b <= bn;
      m_pa <= en_a & an;
      m_pb <= en_b & (pair_sel ? ~an : bn);
      sn = (m_sts & ~clr) | {mh[1], mh};
      m_sts <= sn;
      m_irq <= |(sn & ien);
      m_full <= mh[1]; m_half <= mh[0];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_now(input string tag);
    check(count == m_cnt, {tag, " count"}, int'($signed(count)), int'(m_cnt));
    check({pwm_a, pwm_b} == {m_pa, m_pb}, {tag, " pins"}, int'({pwm_a, pwm_b}), int'({m_pa, m_pb}));
    check(flags == m_sts, {tag, " flags"}, int'(flags), int'(m_sts));
    check({irq, full_evt, half_evt} == {m_irq, m_full, m_half}, {tag, " irq/evt"},
          int'({irq, full_evt, half_evt}), int'({m_irq, m_full, m_half}));
  endtask

  task automatic run_cmp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_now(tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run = 1'b0; clr = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic set_vals(input int a0, a1, a2, a3, a4, a5);
    v[0] = 16'(a0); v[1] = 16'(a1); v[2] = 16'(a2);
    v[3] = 16'(a3); v[4] = 16'(a4); v[5] = 16'(a5);
  endtask

  task automatic t_reset_r1();
    init_v = -16'sd5; pair_sel = 0; en_a = 1; en_b = 1; prsc = 0;
    set_vals(0, 4, 1, 2, 3, 4);
    do_reset();
    check(count == 16'hFFFB, "R1 count=init", int'($signed(count)), -5);
    check(pwm_a == 0 && pwm_b == 0, "R1 pins low", int'({pwm_a, pwm_b}), 0);
    check(flags == 0 && irq == 0, "R1 flags/irq clear", int'({irq, flags}), 0);
    check(full_evt == 0 && half_evt == 0, "R1 events low", int'({full_evt, half_evt}), 0);
  endtask

  task automatic t_count_r2_r3_r4();
    init_v = -16'sd3; set_vals(0, 4, 9, 9, 9, 9); ien = '0;
    do_reset(); run = 1;
    run_cmp(40, "R2 R3 R4 count/reload/half");
    // explicit reload landing: wait for full_evt and check count==init
    while (!full_evt) @(negedge clk);
    check(count == 16'hFFFD, "R3 reload to init", int'($signed(count)), -3);
    check(flags[1] && flags[6], "R3 full and reload flags", int'(flags), 7'h42);
  endtask

  task automatic t_wrap_r2();
    init_v = 16'sd32765; set_vals(32767, -32767, 5, 5, 5, 5);
    do_reset(); run = 1;
    run_cmp(3, "R2 pre-wrap");
    check(count == 16'h8000, "R2 wrap to -32768", int'($signed(count)), -32768);
    run_cmp(12, "R2 wrap run");
  endtask

  task automatic t_prescale_r5();
    init_v = -16'sd2; set_vals(0, 2, 0, 1, 9, 9); en_a = 1;
    prsc = 3'd2; do_reset(); run = 1;
    run_cmp(3, "R5 div4 before tick");
    check(count == 16'hFFFE, "R5 no tick before 4th cycle", int'($signed(count)), -2);
    run_cmp(60, "R5 div4");
    prsc = 3'd3; do_reset(); run = 1; run_cmp(100, "R5 div8");
    prsc = 3'd7; do_reset(); run = 1; run_cmp(800, "R5 div128");
    prsc = 3'd0;
  endtask

  task automatic t_outputs_r6_r7();
    init_v = -16'sd4; set_vals(0, 6, -2, 2, 0, 4);
    pair_sel = 0; en_a = 1; en_b = 1;
    do_reset(); run = 1;
    run_cmp(45, "R6 R7 phase-shifted outputs");
    set_vals(0, 6, 1, 1, 3, 3);
    do_reset(); run = 1;
    run_cmp(30, "R6 R7 fall wins on shared count");
  endtask

  task automatic t_comp_r8();
    init_v = -16'sd4; set_vals(0, 6, -1, 3, -3, 5);
    pair_sel = 1; en_a = 1; en_b = 1;
    do_reset(); run = 1;
    run_cmp(45, "R8 complementary");
    pair_sel = 0;
  endtask

  task automatic t_enable_r9();
    init_v = -16'sd4; set_vals(0, 6, -2, 3, 0, 5);
    en_a = 0; en_b = 1; do_reset(); run = 1;
    run_cmp(14, "R9 A disabled");
    en_a = 1; en_b = 0;
    run_cmp(14, "R9 A back, B disabled");
    en_b = 1;
    run_cmp(14, "R9 both enabled");
  endtask

  task automatic t_run_r10();
    init_v = -16'sd4; set_vals(0, 6, -2, 3, 0, 5);
    prsc = 3'd1; do_reset(); run = 1;
    run_cmp(9, "R10 running");
    run = 0; run_cmp(7, "R10 stopped hold");
    run = 1; run_cmp(11, "R10 resumed");
    run = 0; run_cmp(5, "R10 stopped again");
    run = 1; run_cmp(20, "R10 resumed again");
    prsc = 3'd0;
  endtask

  task automatic t_flags_r11_r12();
    init_v = -16'sd4; set_vals(-1, 6, -2, 3, 0, 5);
    ien = 7'b100_0000; do_reset(); run = 1;
    run_cmp(14, "R11 R12 reload-only mask");
    @(negedge clk); clr = 7'h7F; cmp_now("R11 before clear"); @(negedge clk); clr = '0;
    cmp_now("R11 cleared");
    run_cmp(6, "R11 after clear");
    ien = 7'b000_0101;
    run_cmp(14, "R12 compare mask");
    // clear every cycle: set-wins collisions on each match
    clr = 7'h7F; run_cmp(14, "R11 set wins over clear");
    clr = 7'h04; ien = 7'h7F; run_cmp(14, "R11 R12 partial clear");
    clr = '0; ien = '0; run_cmp(4, "R12 mask off");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    set_vals(0, 0, 0, 0, 0, 0);
    t_reset_r1();
    t_count_r2_r3_r4();
    t_wrap_r2();
    t_prescale_r5();
    t_outputs_r6_r7();
    t_comp_r8();
    t_enable_r9();
    t_run_r10();
    t_flags_r11_r12();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule